// File: doc/BRIEF.md
# Converter Serial Port Emulator

This block models the digital serial port of a delta-sigma converter. It can stand in for the real chip on a test board or in a system model. The conversion result comes in as a parallel word with a strobe. An internal timer, paced by a programmable period, marks the moment each conversion finishes. At that moment the latest strobed word moves into the serial output register, and the shared data-out/ready line drops low to announce it.

A host talks to the block through chip select, serial clock and data-in. It sends 8-bit commands that do one of three things:
- fetch a single word;
- switch the port into streaming mode, where every finished conversion is clocked out without a command;
- leave streaming mode again.

The same line carries both the ready flag and the data. A word that is read late or only partly is overwritten by the next conversion, and a status flag records that this happened. A run of consecutive ones on data-in returns the whole port to its reset state, whatever the byte alignment of the run.

The serial pins are oversampled on the system clock through synchronisers. Data-out changes after a falling serial-clock edge. Data-in is sampled on the rising edge. The serial clock idles high.

Top module: `adc_serial_emu`

## Requirements
- R1: With `conv_period` = P (P > 0), `conv_tick` pulses for one cycle every P system clocks. With P = 0, no conversion ever completes.
- R2: When a conversion completes, the word most recently captured on `word_in` (when `word_valid` was high) goes into the output register. While chip select is low, `dout_rdy` then goes low.
- R3: In single mode, a command whose top six bits are 0b001110 arms one read, provided it arrives while a word is ready. The next 24 falling serial-clock edges then present the word MSB first. After the last rising edge, `dout_rdy` goes high and stays high through further clocks until the next conversion, so a word is read only once.
- R4: A command whose top six bits are 0b001111 raises `stream_mode`. In that mode each ready word is shifted out on the falling edges with no command.
- R5: In streaming mode, a 0b001110xx command clears `stream_mode` only if it completes while a word is ready. Otherwise it is ignored and `stream_mode` stays 1.
- R6: If a conversion completes while the previous word is still unread, the output register is reloaded and the next read starts again at the MSB of the new word. In that case `overrun` goes to 1, and a complete read clears it.
- R7: After 32 consecutive ones on data-in, across byte boundaries, the port resets: `stream_mode` and `overrun` go to 0 and `dout_rdy` goes high. Any zero bit restarts the count.
- R8: The command bit counter restarts when chip select rises, so a partial command is discarded.
- R9: While chip select is high, `dout_rdy` is high.
- R10: After reset, `dout_rdy` = 1, `stream_mode` = 0, `overrun` = 0 and `conv_tick` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, idles high |
| din | input | 1 | Serial data in, commands MSB first |
| word_in | input | 24 | Parallel conversion result |
| word_valid | input | 1 | Captures `word_in` into the staging register |
| conv_period | input | 16 | Conversion period in system clocks, 0 stops conversions |
| dout_rdy | output | 1 | Shared ready (low = word waiting) and serial data line |
| conv_tick | output | 1 | One-cycle pulse when a conversion completes |
| stream_mode | output | 1 | Streaming mode is active |
| overrun | output | 1 | An unread word was overwritten |

## Verification
The assertions check, on every cycle, the rules that local state can decide:
- streaming mode is dropped only while a word is ready, or by the long-ones reset;
- `overrun` rises only on a conversion;
- the long-ones reset clears mode and ready;
- a command and a reset never coincide;
- the bit counters stay within bounds;
- a tick never appears while the period is zero.

Only the bench scenarios can show the serial behaviour: the MSB-first bit order, a word being readable once, the restart of a read at the MSB after an overwrite, the effect of a chip-select rise in the middle of a command, and the exact conversion rate.

// File: rtl/adc_emu_pkg.sv
package adc_emu_pkg;
  localparam int CMD_BITS = 8;

  typedef enum logic [1:0] {
    CMD_NONE,
    CMD_STREAM_ON,
    CMD_FETCH
  } cmd_e;

  function automatic cmd_e decode_cmd(input logic [CMD_BITS-1:0] b);
    if (b[7:2] == 6'b001111) return CMD_STREAM_ON;
    if (b[7:2] == 6'b001110) return CMD_FETCH;
    return CMD_NONE;
  endfunction
endpackage

// File: rtl/adc_pin_sync.sv
module adc_pin_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= {STAGES{RST_VAL}};
    else     sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PER_W-1:0] period,
  output logic             tick
);
  logic [PER_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (period == '0) begin
        cnt <= '0;
      end else if (cnt >= period - PER_W'(1)) begin
        cnt  <= '0;
        tick <= 1'b1;
      end else begin
        cnt <= cnt + PER_W'(1);
      end
    end
  end

  assert_tick_needs_rate_R1: assert property (@(posedge clk) disable iff (rst)
    tick |-> $past(period) != '0);
endmodule

// File: rtl/adc_cmd_rx.sv
module adc_cmd_rx
  import adc_emu_pkg::*;
#(
  parameter int ONES_LEN = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_low,
  input  logic sclk_rise,
  input  logic din_s,
  output logic cmd_valid,
  output cmd_e cmd_code,
  output logic long_ones
);
  localparam int BIT_W  = $clog2(CMD_BITS);
  localparam int ONES_W = $clog2(ONES_LEN);

  logic [CMD_BITS-1:0] sh;
  logic [CMD_BITS-1:0] sh_next;
  logic [BIT_W-1:0]    bit_cnt;
  logic [ONES_W-1:0]   ones_cnt;
  logic                ones_hit;

  assign sh_next  = {sh[CMD_BITS-2:0], din_s};
  assign ones_hit = din_s && (ones_cnt == ONES_W'(ONES_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sh        <= '0;
      bit_cnt   <= '0;
      ones_cnt  <= '0;
      cmd_valid <= 1'b0;
      cmd_code  <= CMD_NONE;
      long_ones <= 1'b0;
    end else begin
      cmd_valid <= 1'b0;
      long_ones <= 1'b0;
      if (!cs_low) begin
        bit_cnt <= '0;
      end else if (sclk_rise) begin
        sh <= sh_next;
        if (ones_hit) begin
          long_ones <= 1'b1;
          ones_cnt  <= '0;
          bit_cnt   <= '0;
        end else begin
          ones_cnt <= din_s ? ones_cnt + ONES_W'(1) : '0;
          if (bit_cnt == BIT_W'(CMD_BITS - 1)) begin
            bit_cnt   <= '0;
            cmd_valid <= 1'b1;
            cmd_code  <= decode_cmd(sh_next);
          end else begin
            bit_cnt <= bit_cnt + BIT_W'(1);
          end
        end
      end
    end
  end

  assert_cmd_not_with_reset_R7: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && long_ones));
  assert_ones_after_one_R7: assert property (@(posedge clk) disable iff (rst)
    long_ones |-> $past(din_s) && $past(sclk_rise));
endmodule

// File: rtl/adc_serial_emu.sv
module adc_serial_emu
  import adc_emu_pkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int PER_W       = 16,
  parameter int ONES_LEN    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  input  logic [WORD_W-1:0] word_in,
  input  logic              word_valid,
  input  logic [PER_W-1:0]  conv_period,
  output logic              dout_rdy,
  output logic              conv_tick,
  output logic              stream_mode,
  output logic              overrun
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

  logic cs_s, sclk_s, din_s, sclk_d;
  logic sclk_rise, sclk_fall, cs_low;
  logic cmd_valid, long_ones;
  cmd_e cmd_code;

  logic [WORD_W-1:0] staged, out_sr;
  logic [CNT_W-1:0]  out_cnt;
  logic              pending, armed, dout_q, reading;

  adc_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
    .clk(clk), .rst(rst), .d(cs_n), .q(cs_s));
  adc_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sclk_sync (
    .clk(clk), .rst(rst), .d(sclk), .q(sclk_s));
  adc_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_din_sync (
    .clk(clk), .rst(rst), .d(din), .q(din_s));

  assign sclk_rise = sclk_s & ~sclk_d;
  assign sclk_fall = ~sclk_s & sclk_d;
  assign cs_low    = ~cs_s;
  assign reading   = pending & (stream_mode | armed);

  adc_conv_timer #(.PER_W(PER_W)) u_timer (
    .clk(clk), .rst(rst), .period(conv_period), .tick(conv_tick));

  adc_cmd_rx #(.ONES_LEN(ONES_LEN)) u_cmd (
    .clk(clk), .rst(rst), .cs_low(cs_low), .sclk_rise(sclk_rise), .din_s(din_s),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .long_ones(long_ones));

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d      <= 1'b1;
      staged      <= '0;
      out_sr      <= '0;
      out_cnt     <= '0;
      pending     <= 1'b0;
      armed       <= 1'b0;
      stream_mode <= 1'b0;
      overrun     <= 1'b0;
      dout_q      <= 1'b1;
      dout_rdy    <= 1'b1;
    end else begin
      sclk_d   <= sclk_s;
      dout_rdy <= cs_s ? 1'b1 : dout_q;
      if (word_valid) staged <= word_in;

      if (long_ones) begin
        stream_mode <= 1'b0;
        pending     <= 1'b0;
        armed       <= 1'b0;
        out_cnt     <= '0;
        overrun     <= 1'b0;
        dout_q      <= 1'b1;
      end else if (conv_tick) begin
        out_sr  <= staged;
        overrun <= overrun | pending;
        pending <= 1'b1;
        armed   <= 1'b0;
        out_cnt <= '0;
        dout_q  <= 1'b0;
      end else begin
        if (cmd_valid) begin
          case (cmd_code)
            CMD_STREAM_ON: stream_mode <= 1'b1;
            CMD_FETCH: begin
              if (pending) begin
                if (stream_mode) stream_mode <= 1'b0;
                else             armed       <= 1'b1;
              end
            end
            default: ;
          endcase
        end
        if (cs_low && sclk_fall) begin
          if (reading && out_cnt < CNT_FULL) begin
            dout_q  <= out_sr[WORD_W-1];
            out_sr  <= {out_sr[WORD_W-2:0], 1'b0};
            out_cnt <= out_cnt + CNT_W'(1);
          end else begin
            dout_q <= ~pending;
          end
        end
        if (cs_low && sclk_rise && reading && out_cnt == CNT_FULL) begin
          pending <= 1'b0;
          armed   <= 1'b0;
          out_cnt <= '0;
          overrun <= 1'b0;
          dout_q  <= 1'b1;
        end
      end
    end
  end

  assert_exit_needs_ready_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(stream_mode) |-> $past(pending) || $past(long_ones));
  assert_overrun_on_conv_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $past(conv_tick));
  assert_long_ones_clears_R7: assert property (@(posedge clk) disable iff (rst)
    long_ones |=> !stream_mode && !pending && !overrun);
  assert_conv_keeps_mode_R4: assert property (@(posedge clk) disable iff (rst)
    (conv_tick && !long_ones) |=> stream_mode == $past(stream_mode));
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
    out_cnt <= CNT_FULL);
  assert_cs_high_idle_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(cs_s) && cs_s) |-> dout_rdy);
endmodule

// File: tb/adc_serial_emu_bench.sv
module adc_serial_emu_bench;
  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1, sclk = 1'b1, din = 1'b0;
  logic [23:0] word_in = '0;
  logic        word_valid = 1'b0;
  logic [15:0] conv_period = '0;
  logic        dout_rdy, conv_tick, stream_mode, overrun;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  adc_serial_emu u_adc_serial_emu (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din),
    .word_in(word_in), .word_valid(word_valid), .conv_period(conv_period),
    .dout_rdy(dout_rdy), .conv_tick(conv_tick), .stream_mode(stream_mode),
    .overrun(overrun));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [31:0] tx, input int n, output logic [31:0] rx);
    rx = '0;
    for (int i = n - 1; i >= 0; i--) begin
      sclk = 1'b0;
      din  = tx[i];
      wait_clk(HALF);
      rx = {rx[30:0], dout_rdy};
      sclk = 1'b1;
      wait_clk(HALF);
    end
    din = 1'b0;
  endtask

  task automatic convert(input logic [23:0] w);
    word_in = w;
    word_valid = 1'b1;
    wait_clk(1);
    word_valid = 1'b0;
    conv_period = 16'd3;
    wait_clk(3);
    conv_period = '0;
    wait_clk(6);
  endtask

  task automatic t_reset;
    check("R10 dout_rdy", dout_rdy, 1);
    check("R10 stream_mode", stream_mode, 0);
    check("R10 overrun", overrun, 0);
    check("R10 conv_tick", conv_tick, 0);
  endtask

  task automatic t_rate;
    int ticks;
    logic [31:0] rx;
    word_in = 24'h123456; word_valid = 1'b1; wait_clk(1); word_valid = 1'b0;
    ticks = 0;
    conv_period = 16'd10;
    for (int i = 0; i < 100; i++) begin
      wait_clk(1);
      if (conv_tick) ticks++;
    end
    conv_period = '0;
    check("R1 ticks at period 10", ticks, 10);
    ticks = 0;
    for (int i = 0; i < 50; i++) begin
      wait_clk(1);
      if (conv_tick) ticks++;
    end
    check("R1 no ticks at period 0", ticks, 0);
    check("R9 cs high keeps line high", dout_rdy, 1);
    check("R6 overrun after unread words", overrun, 1);
    cs_n = 1'b0; wait_clk(6);
    check("R2 ready low when cs drops", dout_rdy, 0);
    xfer(32'h38, 8, rx);
    xfer(0, 24, rx);
    check("R2 latest strobed word", rx, 32'h123456);
    check("R6 overrun cleared by full read", overrun, 0);
  endtask

  task automatic t_single;
    logic [31:0] rx;
    convert(24'hA5C31E);
    check("R2 ready low after conversion", dout_rdy, 0);
    xfer(32'h39, 8, rx);
    check("R3 line low during fetch command", rx, 32'h00);
    xfer(0, 24, rx);
    check("R3 word MSB first", rx, 32'hA5C31E);
    check("R3 high after read", dout_rdy, 1);
    xfer(0, 8, rx);
    check("R3 word read only once", rx, 32'hFF);
  endtask

  task automatic t_restart;
    logic [31:0] rx;
    xfer(32'h3, 4, rx);
    cs_n = 1'b1; wait_clk(12);
    check("R9 line high with cs high", dout_rdy, 1);
    cs_n = 1'b0; wait_clk(6);
    xfer(32'h3C, 8, rx);
    check("R8 aligned after cs rise, R4 stream on", stream_mode, 1);
  endtask

  task automatic t_stream;
    logic [31:0] rx;
    convert(24'h0F1E2D);
    xfer(0, 24, rx);
    check("R4 stream word one", rx, 32'h0F1E2D);
    check("R4 high after stream read", dout_rdy, 1);
    convert(24'hC0FFEE);
    xfer(0, 24, rx);
    check("R4 stream word two", rx, 32'hC0FFEE);
  endtask

  task automatic t_exit;
    logic [31:0] rx;
    xfer(32'h38, 8, rx);
    check("R5 exit ignored while ready high", stream_mode, 1);
    convert(24'h9ABCDE);
    xfer(32'h3A, 8, rx);
    check("R5 data shifted with exit command", rx, 32'h9A);
    check("R5 exit honoured while ready low", stream_mode, 0);
  endtask

  task automatic t_overrun;
    logic [31:0] rx;
    convert(24'h5A5A33);
    check("R6 overrun on partial read", overrun, 1);
    xfer(32'h38, 8, rx);
    xfer(0, 24, rx);
    check("R6 reload restarts at MSB", rx, 32'h5A5A33);
    check("R6 overrun cleared", overrun, 0);
  endtask

  task automatic t_long_ones;
    logic [31:0] rx;
    xfer(32'h3C, 8, rx);
    convert(24'h111111);
    xfer(32'hFFFFFFFF, 31, rx);
    xfer(0, 1, rx);
    xfer(32'hFFFFFFFF, 31, rx);
    check("R7 zero restarts ones count", stream_mode, 1);
    convert(24'h222222);
    convert(24'h333333);
    check("R7 overrun before reset", overrun, 1);
    check("R7 ready low before reset", dout_rdy, 0);
    xfer(1, 1, rx);
    wait_clk(4);
    check("R7 stream cleared", stream_mode, 0);
    check("R7 overrun cleared", overrun, 0);
    check("R7 line high", dout_rdy, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_clk(4);
    rst = 1'b0;
    wait_clk(4);
    t_reset();
    t_rate();
    t_single();
    t_restart();
    t_stream();
    t_exit();
    t_overrun();
    t_long_ones();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule